// File: doc/BRIEF.md
# Multi-Channel ADC Readout Sequencer

This block drives one shared analog-to-digital converter through a fixed list of eleven measurement channels and keeps the latest result of each channel in its own register. The host core selects an operation by writing a mode code, and a channel number for single conversions, on a one-cycle configuration strobe. Three operations exist. A single conversion converts one chosen channel and stops. A round-robin run converts channels 0 to 10 in turn and wraps back to channel 0 until it is told to stop. A one-shot sweep converts every channel once and halts.

Each conversion has two phases. In the sample phase the sequencer holds the channel select and the sample strobe for a fixed number of converter clock ticks. It then raises the convert strobe and waits for the converter's done pulse, which comes with the result. The converter clock is a tick that the system clock is divided down to; the default divide of 83 gives about 1.5 MHz from 125 MHz. When a one-shot sweep finishes, a sticky interrupt flag is raised, and the host clears it by writing a one. Every time a round-robin run finishes channel 10, the sequencer emits a one-cycle sweep pulse. A new mode written while the sequencer is busy takes effect only once the conversion in flight has completed.

Top module: `adc_seq`

## Requirements
- R1: After reset the sequencer is idle: busy_o, adc_sample_o, adc_convert_o, irq_o and sweep_pulse_o are low, and every valid bit is 0.
- R2: Writing mode 1 (single) with a channel number below 11 converts that channel once, stores its result, and returns the sequencer to idle. A single request with channel 11 or above is ignored and starts nothing.
- R3: Writing mode 3 (one-shot) converts channels 0 through 10 in ascending order, exactly once each, and then goes idle.
- R4: When a one-shot sweep completes, irq_o goes high and stays high until irq_clr_i is pulsed. Clearing it drops irq_o on the following cycle.
- R5: Writing mode 2 (round-robin) converts channels in ascending order and wraps from 10 back to 0 without stopping. sweep_pulse_o is high for exactly one cycle each time channel 10 completes. This mode never raises irq_o.
- R6: A conversion holds adc_sample_o for SAMPLE_TICKS converter ticks and then holds adc_convert_o until adc_done_i. The two strobes are never high together, and adc_chan_o stays constant through a conversion.
- R7: A channel's result register and valid bit change only when that channel's own conversion completes. Starting a new operation clears every valid bit, and this clear takes priority over a result stored in the same cycle. Results themselves are kept across operations.
- R8: A mode written while busy is held until the conversion in flight completes and stores its result. The held request then replaces the running operation. If the held request is mode 0 or an invalid single request, the sequencer stops.
- R9: The converter tick occurs once every CLK_DIV system cycles. A sample phase therefore lasts between (SAMPLE_TICKS-1)*CLK_DIV+1 and SAMPLE_TICKS*CLK_DIV cycles.
- R10: A done pulse that arrives while adc_convert_o is low is ignored: no result register and no valid bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | One-cycle strobe that writes the mode and channel |
| cfg_mode_i | input | 2 | 0 stop, 1 single, 2 round-robin, 3 one-shot |
| cfg_chan_i | input | CH_W | Channel for a single conversion |
| irq_clr_i | input | 1 | Write-one-to-clear for the interrupt flag |
| adc_chan_o | output | CH_W | Channel select to the converter |
| adc_sample_o | output | 1 | Sample phase strobe |
| adc_convert_o | output | 1 | Convert phase strobe |
| adc_done_i | input | 1 | Converter done pulse |
| adc_result_i | input | RES_W | Conversion result, valid with done |
| rd_chan_i | input | CH_W | Result register read select |
| rd_data_o | output | RES_W | Selected result register |
| valid_o | output | NUM_CH | Per-channel result valid bits |
| busy_o | output | 1 | An operation is in progress |
| irq_o | output | 1 | Sticky one-shot sweep complete flag |
| sweep_pulse_o | output | 1 | One-cycle pulse per completed round-robin sweep |

## Verification
The bench goes after the request that arrives mid-sweep. A design that cut the conversion short would lose channel 3's result or log an extra channel, and one that applied the request at once would skip the wait for done. Round-robin runs go past two wraps, so a design that stopped at channel 10 or repeated a channel would break the logged order, and the pulse count would expose a pulse that is missing or stretched. Out-of-range single requests and stray done pulses while idle are checked against register contents that should not change. The interrupt is checked both for stickiness and for clearing, and the width of every sample phase is checked against the divider window.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_SINGLE  = 2'd1,
    MODE_RROBIN  = 2'd2,
    MODE_ONESHOT = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_CONV   = 2'd2
  } state_e;
endpackage

// File: rtl/adc_seq_tick.sv
module adc_seq_tick #(
  parameter int CLK_DIV = 83
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(CLK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH       = 11,
  parameter int CH_W         = 4,
  parameter int SAMPLE_TICKS = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            cfg_we_i,
  input  logic [1:0]      cfg_mode_i,
  input  logic [CH_W-1:0] cfg_chan_i,
  input  logic            adc_done_i,
  output logic [CH_W-1:0] chan_o,
  output logic            sample_o,
  output logic            convert_o,
  output logic            busy_o,
  output logic            wr_en_o,
  output logic            clr_all_o,
  output logic            irq_set_o,
  output logic            sweep_o
);
  localparam int STW = $clog2(SAMPLE_TICKS + 1);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  state_e          st_q, st_d;
  mode_e           mode_q, mode_d;
  logic [CH_W-1:0] chan_q, chan_d;
  logic [STW-1:0]  tcnt_q, tcnt_d;
  logic            pend_q, pend_d;
  logic [1:0]      pmode_q, pmode_d;
  logic [CH_W-1:0] pchan_q, pchan_d;

  logic            launch;
  logic [1:0]      lmode;
  logic [CH_W-1:0] lchan;
  logic            lvalid;
  logic            last;

  assign last   = (chan_q == LAST_CH);
  assign lvalid = (lmode != MODE_OFF) &&
                  !((lmode == MODE_SINGLE) && (lchan > LAST_CH));

  always_comb begin
    st_d = st_q; mode_d = mode_q; chan_d = chan_q; tcnt_d = tcnt_q;
    pend_d = pend_q; pmode_d = pmode_q; pchan_d = pchan_q;
    wr_en_o = 1'b0; clr_all_o = 1'b0; irq_set_o = 1'b0; sweep_o = 1'b0;
    launch = 1'b0; lmode = cfg_mode_i; lchan = cfg_chan_i;

    if (st_q != ST_IDLE && cfg_we_i) begin
      pend_d = 1'b1; pmode_d = cfg_mode_i; pchan_d = cfg_chan_i;
    end

    unique case (st_q)
      ST_IDLE: launch = cfg_we_i;
      ST_SAMPLE: if (tick_i) begin
        if (tcnt_q == STW'(SAMPLE_TICKS - 1)) begin
          st_d = ST_CONV; tcnt_d = '0;
        end else tcnt_d = tcnt_q + 1'b1;
      end
      ST_CONV: if (adc_done_i) begin
        wr_en_o = 1'b1;
        if (cfg_we_i || pend_q) begin
          // deferred request replaces the running operation
          launch = 1'b1;
          lmode  = cfg_we_i ? cfg_mode_i : pmode_q;
          lchan  = cfg_we_i ? cfg_chan_i : pchan_q;
          pend_d = 1'b0;
        end else begin
          unique case (mode_q)
            MODE_RROBIN: begin
              st_d = ST_SAMPLE;
              if (last) begin sweep_o = 1'b1; chan_d = '0; end
              else chan_d = chan_q + 1'b1;
            end
            MODE_ONESHOT: begin
              if (last) begin irq_set_o = 1'b1; st_d = ST_IDLE; end
              else begin chan_d = chan_q + 1'b1; st_d = ST_SAMPLE; end
            end
            default: st_d = ST_IDLE;
          endcase
        end
      end
      default: st_d = ST_IDLE;
    endcase

    if (launch) begin
      if (lvalid) begin
        mode_d    = mode_e'(lmode);
        chan_d    = (lmode == MODE_SINGLE) ? lchan : '0;
        tcnt_d    = '0;
        st_d      = ST_SAMPLE;
        clr_all_o = 1'b1;
      end else st_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; mode_q <= MODE_OFF; chan_q <= '0; tcnt_q <= '0;
      pend_q <= 1'b0; pmode_q <= '0; pchan_q <= '0;
    end else begin
      st_q <= st_d; mode_q <= mode_d; chan_q <= chan_d; tcnt_q <= tcnt_d;
      pend_q <= pend_d; pmode_q <= pmode_d; pchan_q <= pchan_d;
    end
  end

  assign chan_o    = chan_q;
  assign sample_o  = (st_q == ST_SAMPLE);
  assign convert_o = (st_q == ST_CONV);
  assign busy_o    = (st_q != ST_IDLE);
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs #(
  parameter int NUM_CH = 11,
  parameter int CH_W   = 4,
  parameter int RES_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CH_W-1:0]   wchan_i,
  input  logic [RES_W-1:0]  wdata_i,
  input  logic              clr_all_i,
  input  logic [CH_W-1:0]   rd_chan_i,
  output logic [RES_W-1:0]  rd_data_o,
  output logic [NUM_CH-1:0] valid_o
);
  logic [RES_W-1:0] res_q [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = we_i && (wchan_i == CH_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_q[g]   <= '0;
        valid_o[g] <= 1'b0;
      end else begin
        if (hit) res_q[g] <= wdata_i;
        if (clr_all_i)  valid_o[g] <= 1'b0;
        else if (hit)   valid_o[g] <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (rd_chan_i == CH_W'(i)) rd_data_o = res_q[i];
  end
endmodule

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int NUM_CH       = 11,
  parameter int CH_W         = $clog2(NUM_CH),
  parameter int RES_W        = 10,
  parameter int CLK_DIV      = 83,
  parameter int SAMPLE_TICKS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic [CH_W-1:0]   cfg_chan_i,
  input  logic              irq_clr_i,
  output logic [CH_W-1:0]   adc_chan_o,
  output logic              adc_sample_o,
  output logic              adc_convert_o,
  input  logic              adc_done_i,
  input  logic [RES_W-1:0]  adc_result_i,
  input  logic [CH_W-1:0]   rd_chan_i,
  output logic [RES_W-1:0]  rd_data_o,
  output logic [NUM_CH-1:0] valid_o,
  output logic              busy_o,
  output logic              irq_o,
  output logic              sweep_pulse_o
);
  logic tick, res_we, clr_all, irq_set, sweep;
  logic irq_q, sweep_q;

  adc_seq_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  adc_seq_ctrl #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .SAMPLE_TICKS(SAMPLE_TICKS)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .tick_i(tick),
    .cfg_we_i, .cfg_mode_i, .cfg_chan_i,
    .adc_done_i,
    .chan_o(adc_chan_o),
    .sample_o(adc_sample_o),
    .convert_o(adc_convert_o),
    .busy_o,
    .wr_en_o(res_we),
    .clr_all_o(clr_all),
    .irq_set_o(irq_set),
    .sweep_o(sweep)
  );

  adc_seq_regs #(.NUM_CH(NUM_CH), .CH_W(CH_W), .RES_W(RES_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(res_we),
    .wchan_i(adc_chan_o),
    .wdata_i(adc_result_i),
    .clr_all_i(clr_all),
    .rd_chan_i,
    .rd_data_o,
    .valid_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q   <= 1'b0;
      sweep_q <= 1'b0;
    end else begin
      sweep_q <= sweep;
      if (irq_set)        irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
    end
  end

  assign irq_o         = irq_q;
  assign sweep_pulse_o = sweep_q;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int NUM_CH = 11,
  parameter int CH_W   = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sample_i,
  input logic            convert_i,
  input logic [CH_W-1:0] chan_i,
  input logic            done_i,
  input logic            busy_i,
  input logic            wr_en_i,
  input logic            irq_set_i,
  input logic            irq_i,
  input logic            irq_clr_i,
  input logic            sweep_i
);
  a_r6_phase_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_i && convert_i));

  a_r6_chan_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    convert_i |-> $stable(chan_i));

  a_r6_chan_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (chan_i < CH_W'(NUM_CH)));

  a_r10_write_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (convert_i && done_i));

  a_r4_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !irq_clr_i) |=> irq_i);

  a_r4_irq_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !irq_set_i) |=> !irq_i);

  a_r3_idle_after_sweep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_set_i |=> !busy_i);

  a_r5_pulse_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sweep_i |=> !sweep_i);
endmodule

bind adc_seq adc_seq_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk_i(clk_i),
  .rst_ni(rst_ni),
  .sample_i(adc_sample_o),
  .convert_i(adc_convert_o),
  .chan_i(adc_chan_o),
  .done_i(adc_done_i),
  .busy_i(busy_o),
  .wr_en_i(res_we),
  .irq_set_i(irq_set),
  .irq_i(irq_o),
  .irq_clr_i(irq_clr_i),
  .sweep_i(sweep_pulse_o)
);

// File: tb/adc_seq_bench.sv
`timescale 1ns/1ps
module adc_seq_bench;
  localparam int NUM_CH = 11;
  localparam int CH_W   = 4;
  localparam int RES_W  = 10;
  localparam int DIV    = 4;
  localparam int ST     = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_mode = '0;
  logic [CH_W-1:0] cfg_chan = '0;
  logic irq_clr = 1'b0;
  logic [CH_W-1:0] adc_chan;
  logic adc_sample, adc_convert;
  logic adc_done = 1'b0;
  logic [RES_W-1:0] adc_result = '0;
  logic [CH_W-1:0] rd_chan = '0;
  logic [RES_W-1:0] rd_data;
  logic [NUM_CH-1:0] valid;
  logic busy, irq, sweep_pulse;

  always #4 clk = ~clk;

  adc_seq #(.NUM_CH(NUM_CH), .CH_W(CH_W), .RES_W(RES_W),
            .CLK_DIV(DIV), .SAMPLE_TICKS(ST)) u_adc_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_mode_i(cfg_mode), .cfg_chan_i(cfg_chan),
    .irq_clr_i(irq_clr),
    .adc_chan_o(adc_chan), .adc_sample_o(adc_sample), .adc_convert_o(adc_convert),
    .adc_done_i(adc_done), .adc_result_i(adc_result),
    .rd_chan_i(rd_chan), .rd_data_o(rd_data), .valid_o(valid),
    .busy_o(busy), .irq_o(irq), .sweep_pulse_o(sweep_pulse)
  );

  int checks = 0, errors = 0;
  int conv_n = 0;
  int log_ch [512];
  logic [RES_W-1:0] exp_res [NUM_CH];
  int inj_req = 0, inj_seen = 0;
  int smp_run = 0, smp_min = 1000, smp_max = 0;
  int pulses = 0, pulse_run = 0, pulse_long = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // converter model
  initial begin
    for (int i = 0; i < NUM_CH; i++) exp_res[i] = '0;
    forever begin
      @(negedge clk);
      if (inj_req != inj_seen) begin
        inj_seen = inj_req;
        adc_done = 1'b1; adc_result = '1;
        @(negedge clk);
        adc_done = 1'b0;
      end else if (adc_convert) begin
        repeat (3) @(negedge clk);
        adc_result = {adc_chan, 6'(conv_n)};
        exp_res[adc_chan] = {adc_chan, 6'(conv_n)};
        if (conv_n < 512) log_ch[conv_n] = int'(adc_chan);
        conv_n++;
        adc_done = 1'b1;
        @(negedge clk);
        adc_done = 1'b0;
      end
    end
  end

  // monitors: sample width and sweep pulses
  always @(negedge clk) begin
    if (adc_sample) smp_run++;
    else if (smp_run > 0) begin
      if (smp_run < smp_min) smp_min = smp_run;
      if (smp_run > smp_max) smp_max = smp_run;
      smp_run = 0;
    end
    if (sweep_pulse) begin
      if (pulse_run == 0) pulses++;
      pulse_run++;
      if (pulse_run > 1) pulse_long++;
    end else pulse_run = 0;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  task automatic write_mode(input logic [1:0] m, input logic [CH_W-1:0] c);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mode = m; cfg_chan = c;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
  endtask

  task automatic read_ch(input int ch, output logic [RES_W-1:0] d);
    @(negedge clk);
    rd_chan = CH_W'(ch);
    #1 d = rd_data;
  endtask

  initial begin
    logic [RES_W-1:0] d;
    int base, n, ok, p0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !adc_sample && !adc_convert && !irq && !sweep_pulse, "R1 outputs",
        int'({busy, adc_sample, adc_convert, irq, sweep_pulse}), 0);
    chk(valid == '0, "R1 valid", int'(valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 single conversion on every channel
    for (int ch = 0; ch < NUM_CH; ch++) begin
      base = conv_n;
      write_mode(2'd1, CH_W'(ch));
      wait_idle();
      chk(conv_n - base == 1 && log_ch[base] == ch, "R2 single channel", log_ch[base], ch);
      chk(valid == NUM_CH'(1 << ch), "R7 single valid", int'(valid), 1 << ch);
      read_ch(ch, d);
      chk(d == exp_res[ch], "R2 single result", int'(d), int'(exp_res[ch]));
    end

    // R2 out-of-range single requests ignored
    for (int ch = NUM_CH; ch < 16; ch++) begin
      base = conv_n;
      write_mode(2'd1, CH_W'(ch));
      repeat (4 * DIV) @(negedge clk);
      chk(!busy && conv_n == base, "R2 out of range ignored", conv_n - base, 0);
    end

    // R3/R4 one-shot sweep
    base = conv_n;
    write_mode(2'd3, '0);
    wait_idle();
    n = conv_n - base;
    ok = 1;
    for (int i = 0; i < n; i++) if (log_ch[base + i] != i) ok = 0;
    chk(n == NUM_CH && ok == 1, "R3 one-shot order", n, NUM_CH);
    chk(valid == '1, "R3 all valid", int'(valid), (1 << NUM_CH) - 1);
    @(negedge clk);
    chk(irq, "R4 irq set", int'(irq), 1);
    repeat (20) @(negedge clk);
    chk(irq && !busy, "R4 irq sticky", int'(irq), 1);
    for (int ch = 0; ch < NUM_CH; ch++) begin
      read_ch(ch, d);
      chk(d == exp_res[ch], "R3 sweep result", int'(d), int'(exp_res[ch]));
    end
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk(!irq, "R4 irq cleared", int'(irq), 0);

    // R7 other channels keep results; valid cleared by new operation
    write_mode(2'd1, 4'd4);
    wait_idle();
    chk(valid == NUM_CH'(1 << 4), "R7 valid cleared on new op", int'(valid), 1 << 4);
    for (int ch = 0; ch < NUM_CH; ch++) begin
      read_ch(ch, d);
      chk(d == exp_res[ch], "R7 retained result", int'(d), int'(exp_res[ch]));
    end

    // R10 stray done while idle
    inj_req++;
    repeat (4) @(negedge clk);
    chk(valid == NUM_CH'(1 << 4), "R10 stray done valid", int'(valid), 1 << 4);
    for (int ch = 0; ch < NUM_CH; ch++) begin
      read_ch(ch, d);
      chk(d == exp_res[ch], "R10 stray done result", int'(d), int'(exp_res[ch]));
    end

    // R5 round-robin with wraps, stopped by mode 0 (R8)
    base = conv_n; p0 = pulses;
    write_mode(2'd2, '0);
    for (int i = 0; i < 20000 && (conv_n - base) < 26; i++) @(negedge clk);
    write_mode(2'd0, '0);
    wait_idle();
    n = conv_n - base;
    ok = 1;
    for (int i = 0; i < n; i++) if (log_ch[base + i] != i % NUM_CH) ok = 0;
    chk(ok == 1 && n >= 26, "R5 wrap order", n, 26);
    repeat (3) @(negedge clk);
    chk(pulses - p0 == n / NUM_CH, "R5 sweep pulses", pulses - p0, n / NUM_CH);
    chk(pulse_long == 0, "R5 pulse width", pulse_long, 0);
    chk(!irq, "R5 no irq", int'(irq), 0);

    // R8 mid-sweep request deferred to end of conversion
    base = conv_n;
    write_mode(2'd3, '0);
    for (int i = 0; i < 20000 && !((conv_n - base) == 3 && adc_sample); i++) @(negedge clk);
    write_mode(2'd1, 4'd7);
    wait_idle();
    n = conv_n - base;
    ok = (n == 5) && log_ch[base] == 0 && log_ch[base + 1] == 1 &&
         log_ch[base + 2] == 2 && log_ch[base + 3] == 3 && log_ch[base + 4] == 7;
    chk(ok == 1, "R8 deferred switch", n, 5);
    chk(valid == NUM_CH'(1 << 7), "R8 valid after switch", int'(valid), 1 << 7);
    read_ch(3, d);
    chk(d == exp_res[3], "R8 in-flight result kept", int'(d), int'(exp_res[3]));
    repeat (2) @(negedge clk);
    chk(!irq, "R8 aborted sweep no irq", int'(irq), 0);

    // R6/R9 sample phase width window
    chk(smp_min >= (ST - 1) * DIV + 1 && smp_max <= ST * DIV, "R9 sample width",
        smp_max, ST * DIV);
    chk(smp_min >= (ST - 1) * DIV + 1, "R6 sample ticks", smp_min, (ST - 1) * DIV + 1);

    finish_run();
  end
endmodule